// File: doc/BRIEF.md
# Shared-Datapath Five-Function Arithmetic Unit

This block is a purely combinational 32-bit arithmetic unit. It takes two operands and a 3-bit function code and returns one result word in the same evaluation, with no clock and no stored state. It offers five operations: add, subtract, increment, decrement and multiply.

The datapath holds exactly one adder, one subtractor and one 16x16 multiplier. Increment and decrement do not get hardware of their own. The lowest function bit steers the second input of both the adder and the subtractor, picking either operand B or the constant one. The two upper function bits then pick which of the three unit outputs reaches the result port. Whenever the top bit is set, the multiply result is chosen and the two lower bits are ignored.

The block has no selection state machine. Operation selection is a single combinational decode. Each of the eight code values is named in the requirements below.

Top module: `shared_alu`

## Requirements
- R1: With function code 3'b000 the result equals op_a + op_b, truncated to 32 bits (modulo 2^32).
- R2: With function code 3'b001 the result equals op_a + 1 modulo 2^32, so 32'hFFFF_FFFF gives 32'h0000_0000.
- R3: With function code 3'b010 the result equals op_a - op_b modulo 2^32, so a smaller op_a wraps to a large value.
- R4: With function code 3'b011 the result equals op_a - 1 modulo 2^32, so 32'h0000_0000 gives 32'hFFFF_FFFF.
- R5: With any function code whose bit 2 is 1 (3'b100, 3'b101, 3'b110, 3'b111) the result is the unsigned product of op_a[15:0] and op_b[15:0]. The two low code bits and the upper 16 bits of both operands have no effect on it.
- R6: For every function code and every fully known operand pair, the result carries no unknown bits.
- R7: The product is the full 32-bit value with no truncation, so 16'hFFFF times 16'hFFFF gives 32'hFFFE_0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| f_code | input | 3 | Function select: bit 0 picks B or one for add/subtract, bits 2:1 pick the result source |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; only bits 15:0 reach the multiplier |
| result | output | 32 | Selected arithmetic result |

## Verification
The hardest cases to reach are the ones where inputs that should not matter get non-trivial values. These are the upper halves of both operands during a multiply, and the low code bits when bit 2 is set. Random operands seldom expose a design that leaks them into the result. The sweep therefore drives every operand pair under all eight function codes. It uses pairs whose upper 16 bits differ while the lower halves stay the same, and checks that all four multiply codes give the same product. Wrap-around is reached directly with all-ones for increment and zero for decrement.

// File: rtl/shared_alu_pkg.sv
package shared_alu_pkg;

    // Source chosen by the output multiplexer
    typedef enum logic [1:0] {
        SRC_ADDER = 2'd0,
        SRC_SUBTR = 2'd1,
        SRC_MULT  = 2'd2
    } result_src_e;

    // Decode the upper function bits into a result source
    function automatic result_src_e decode_source(input logic [2:0] code);
        result_src_e src;
        unique case (code[2:1])
            2'b00:   src = SRC_ADDER;
            2'b01:   src = SRC_SUBTR;
            default: src = SRC_MULT;
        endcase
        return src;
    endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_x,
    input  logic [WIDTH-1:0] in_y,
    output logic [WIDTH-1:0] sum
);
    // Modulo 2^WIDTH; no carry out
    assign sum = in_x + in_y;
endmodule

// File: rtl/alu_subtractor.sv
module alu_subtractor #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] in_x,
    input  logic [WIDTH-1:0] in_y,
    output logic [WIDTH-1:0] diff
);
    // Modulo 2^WIDTH; no borrow out
    assign diff = in_x - in_y;
endmodule

// File: rtl/alu_multiplier.sv
module alu_multiplier #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]   in_x,
    input  logic [WIDTH-1:0]   in_y,
    output logic [2*WIDTH-1:0] product
);
    localparam int PW = 2 * WIDTH;

    logic [PW-1:0] ext_x;
    logic [PW-1:0] ext_y;

    // Zero-extend so the unsigned product keeps all of its bits
    assign ext_x   = {{WIDTH{1'b0}}, in_x};
    assign ext_y   = {{WIDTH{1'b0}}, in_y};
    assign product = ext_x * ext_y;
endmodule

// File: rtl/shared_alu.sv
module shared_alu
    import shared_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 16
) (
    input  logic [2:0]        f_code,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] result
);
    localparam int PROD_W = 2 * MUL_W;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] second_in;
    logic [DATA_W-1:0] add_out;
    logic [DATA_W-1:0] sub_out;
    logic [PROD_W-1:0] mul_raw;
    logic [DATA_W-1:0] mul_out;
    result_src_e       src_sel;

    // Operand multiplexer shared by adder and subtractor
    assign second_in = f_code[0] ? ONE : op_b;

    alu_adder #(.WIDTH(DATA_W)) u_adder (
        .in_x (op_a),
        .in_y (second_in),
        .sum  (add_out)
    );

    alu_subtractor #(.WIDTH(DATA_W)) u_subtr (
        .in_x (op_a),
        .in_y (second_in),
        .diff (sub_out)
    );

    alu_multiplier #(.WIDTH(MUL_W)) u_mult (
        .in_x    (op_a[MUL_W-1:0]),
        .in_y    (op_b[MUL_W-1:0]),
        .product (mul_raw)
    );

    // Fit the product to the result width
    generate
        if (PROD_W >= DATA_W) begin : g_prod_trunc
            assign mul_out = mul_raw[DATA_W-1:0];
        end else begin : g_prod_ext
            assign mul_out = {{(DATA_W-PROD_W){1'b0}}, mul_raw};
        end
    endgenerate

    assign src_sel = decode_source(f_code);

    // Output multiplexer: every code maps to a source, so no latch
    always_comb begin
        unique case (src_sel)
            SRC_ADDER: result = add_out;
            SRC_SUBTR: result = sub_out;
            SRC_MULT:  result = mul_out;
            default:   result = mul_out;
        endcase
    end

endmodule

// File: rtl/shared_alu_checker.sv
module shared_alu_checker #(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 16
) (
    input logic [2:0]        f_code,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] result
);
    localparam int PROD_W = 2 * MUL_W;
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [PROD_W-1:0] ref_x;
    logic [PROD_W-1:0] ref_y;
    logic [PROD_W-1:0] ref_prod;
    logic [DATA_W-1:0] ref_mul;
    logic              inputs_known;

    assign ref_x        = {{MUL_W{1'b0}}, op_a[MUL_W-1:0]};
    assign ref_y        = {{MUL_W{1'b0}}, op_b[MUL_W-1:0]};
    assign ref_prod     = ref_x * ref_y;
    assign ref_mul      = DATA_W'(ref_prod);
    assign inputs_known = !$isunknown({f_code, op_a, op_b});

    always_comb begin
        if (inputs_known) begin
            if (f_code == 3'b000)
                assert_add_R1: assert (result == op_a + op_b);
            if (f_code == 3'b001)
                assert_inc_R2: assert (result == op_a + ONE);
            if (f_code == 3'b010)
                assert_sub_R3: assert (result == op_a - op_b);
            if (f_code == 3'b011)
                assert_dec_R4: assert (result == op_a - ONE);
            if (f_code[2])
                assert_mul_R5: assert (result == ref_mul);
            assert_known_R6: assert (!$isunknown(result));
        end
    end
endmodule

bind shared_alu shared_alu_checker #(
    .DATA_W (DATA_W),
    .MUL_W  (MUL_W)
) u_chk (
    .f_code (f_code),
    .op_a   (op_a),
    .op_b   (op_b),
    .result (result)
);

// File: tb/shared_alu_tb.sv
module shared_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  f_code;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shared_alu u_dut (
        .f_code (f_code),
        .op_a   (op_a),
        .op_b   (op_b),
        .result (result)
    );

    function automatic logic [31:0] expect_of(input logic [2:0] f,
                                              input logic [31:0] a,
                                              input logic [31:0] b);
        logic [31:0] pa = {16'h0, a[15:0]};
        logic [31:0] pb = {16'h0, b[15:0]};
        if (f[2]) return pa * pb;        // R5
        case (f[1:0])
            2'b00:   return a + b;       // R1
            2'b01:   return a + 32'd1;   // R2
            2'b10:   return a - b;       // R3
            default: return a - 32'd1;   // R4
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] f);
        if (f[2]) return "R5";
        case (f[1:0])
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: f=%b a=%h b=%h got %h expected %h",
                     req, f_code, op_a, op_b, got, exp);
        end
    endtask

    task automatic apply_and_check(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        f_code = f; op_a = a; op_b = b;
        #1;
        check(result, expect_of(f, a, b), tag_of(f));
        checks++;                                   // R6
        if ($isunknown(result)) begin
            fails++;
            $display("FAIL R6: f=%b got %h expected known value", f, result);
        end
    endtask

    logic [31:0] pat_a [12];
    logic [31:0] pat_b [12];

    initial begin
        f_code = 3'b000; op_a = '0; op_b = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(result, 32'h0, "R1");                 // idle state: 0 + 0

        pat_a[0] = 32'h0000_0000; pat_b[0] = 32'h0000_0000;
        pat_a[1] = 32'hFFFF_FFFF; pat_b[1] = 32'hFFFF_FFFF;
        pat_a[2] = 32'h0000_0000; pat_b[2] = 32'h0000_0001;
        pat_a[3] = 32'h0000_FFFF; pat_b[3] = 32'h0000_FFFF;
        pat_a[4] = 32'hABCD_1234; pat_b[4] = 32'h5A5A_0003;
        pat_a[5] = 32'h0000_1234; pat_b[5] = 32'h0000_0003;
        pat_a[6] = 32'h8000_0000; pat_b[6] = 32'h8000_0000;
        pat_a[7] = 32'h7FFF_FFFF; pat_b[7] = 32'h0000_0001;
        for (int i = 8; i < 12; i++) begin
            pat_a[i] = $urandom;
            pat_b[i] = $urandom;
        end

        for (int p = 0; p < 12; p++)
            for (int f = 0; f < 8; f++)
                apply_and_check(3'(f), pat_a[p], pat_b[p]);

        // R2 / R4 wrap corners
        apply_and_check(3'b001, 32'hFFFF_FFFF, 32'h1234_5678);
        check(result, 32'h0000_0000, "R2");
        apply_and_check(3'b011, 32'h0000_0000, 32'h1234_5678);
        check(result, 32'hFFFF_FFFF, "R4");
        apply_and_check(3'b010, 32'h0000_0005, 32'h0000_0007);
        check(result, 32'hFFFF_FFFE, "R3");

        // R7 full-width product
        apply_and_check(3'b100, 32'h0000_FFFF, 32'h0000_FFFF);
        check(result, 32'hFFFE_0001, "R7");

        // R5: upper halves and low code bits ignored
        for (int f = 4; f < 8; f++) begin
            apply_and_check(3'(f), 32'hDEAD_0102, 32'hBEEF_0304);
            check(result, 32'h0003_0A08, "R5");
        end

        // random sweep
        for (int n = 0; n < 400; n++)
            apply_and_check(3'($urandom_range(0, 7)), $urandom, $urandom);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                checks++;
                $display("FAIL watchdog: run did not complete, got timeout expected finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule